// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This block sits beside a single-precision floating-point datapath and turns the datapath's per-operation indications into IEEE-style exception flags. It also decides whether the datapath's own result must be replaced. The datapath does the rounding itself. It presents the exponent before rounding, the exponent after mantissa rounding, the result sign, a zero-magnitude indication, operand NaN and infinity indications, and an invalid-operation indication. The unit registers the six flags, plus an override word, on the clock edge that ends the operation strobe.

The replacement word is chosen in one of three ways:

- A result with no mathematical meaning, or one that involves a NaN, is replaced by the default quiet NaN.
- A float-to-integer conversion of a NaN is replaced by all-ones.
- An overflowing result is replaced by either a signed infinity or the signed largest finite value. The rounding mode and the sign decide which one.

Software can set or clear the divide-by-zero flag through a one-bit write port. No operation ever sets that flag, and every floating-point operation clears it.

Top module: `fpx_status_unit`

## Requirements
- R1: The `status` word holds divide-by-zero at bit 9, underflow at bit 10, overflow at bit 11, operand error at bit 12, signaling NaN at bit 13 and NaN at bit 14. All other bits read 0. After reset all six flags are 0 and `res_ovr` is 0.
- R2: Divide-by-zero changes only in two ways. A software write (`dz_wr_en`=1) loads `dz_wr_val`. Otherwise a floating-point operation clears it. If a write and a floating-point operation arrive in the same cycle, the write wins.
- R3: An operation with `op_is_float`=0 leaves all six flags unchanged and gives `res_ovr`=0.
- R4: Underflow is judged on the unrounded biased exponent. It is set when `exp_unrnd` is at most 0 and `mag_zero`=0, even if rounding brings `exp_rnd` back to 1 or more. A zero magnitude never sets it.
- R5: Overflow is judged on the rounded biased exponent. It is set when `exp_rnd` is 255 or more. A rounded exponent of 254 (largest value 0x7F7FFFFF) never sets it, in any mode. An infinite operand suppresses both overflow and underflow.
- R6: On overflow, `res_ovr`=1 and `res_word` depends on `rnd_mode` and the sign. With 0 (nearest) the word is a signed infinity. With 1 (toward zero) it is the signed largest finite value. With 2 (toward plus infinity) it is +infinity for positive results and 0xFF7FFFFF for negative ones. With 3 (toward minus infinity) it is 0x7F7FFFFF for positive results and 0xFF800000 for negative ones.
- R7: An arithmetic-class operation (`op_class` 0 or 3) with `op_invalid`=1 sets operand error and NaN and returns 0x7FFFFFFF.
- R8: An arithmetic or absolute-value (`op_class`=1) operation sets NaN and returns 0x7FFFFFFF when either operand is NaN. It also sets signaling NaN when either operand is signaling.
- R9: A float-to-integer conversion (`op_class`=2) of a NaN sets NaN, sets signaling NaN if the operand was signaling, and returns 0xFFFFFFFF. A conversion never sets underflow, overflow or operand error.
- R10: Each floating-point operation replaces the five floating-point flags with its own outcome. The flags and the override appear one clock after the strobe. `res_ovr` and `res_word` are 0 in any cycle that follows no floating-point operation or follows one without an override.
- R11: A NaN outcome takes precedence over overflow and underflow: when NaN is set by an operation, its overflow and underflow flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_is_float | input | 1 | 1 = floating-point operation, 0 = fixed-point |
| op_class | input | 2 | 0 arithmetic, 1 absolute value, 2 float-to-integer, 3 treated as arithmetic |
| src_a_nan | input | 1 | Operand A is a NaN |
| src_a_snan | input | 1 | Operand A is a signaling NaN |
| src_b_nan | input | 1 | Operand B is a NaN |
| src_b_snan | input | 1 | Operand B is a signaling NaN |
| src_a_inf | input | 1 | Operand A is infinite |
| src_b_inf | input | 1 | Operand B is infinite |
| op_invalid | input | 1 | Datapath found the operation invalid for its operands |
| mag_zero | input | 1 | Unrounded result magnitude is zero |
| res_sign | input | 1 | Sign of the rounded result |
| exp_unrnd | input | 10 | Signed biased exponent before rounding |
| exp_rnd | input | 10 | Signed biased exponent after mantissa rounding |
| rnd_mode | input | 2 | Rounding mode, encoding as in R6 |
| dz_wr_en | input | 1 | Software write strobe for divide-by-zero |
| dz_wr_val | input | 1 | Value written to divide-by-zero |
| status | output | 16 | Flag register, layout as in R1 |
| res_ovr | output | 1 | Replace the datapath result with `res_word` |
| res_word | output | 32 | Replacement result word |

## Verification
The overflow path is tried at rounded exponents of 254, 255 and 256. These points separate the exact boundary from a rounding carry that runs past it. All four rounding modes are tried with both signs, which tells apart an infinity from a saturated value in each of the eight cases. Underflow is tried three ways:

- an unrounded exponent of 0 that rounds back to a normal value, which shows the test is made before rounding;
- a negative exponent;
- a zero magnitude, which must not flag.

NaN, signaling NaN, invalid and infinite operands are combined with overflowing exponents, which shows the precedence between the outcomes. Fixed-point strobes and software writes, alone and in the same cycle as a floating-point operation, show which events may touch the divide-by-zero flag and the other five flags.

// File: rtl/fpx_pkg.sv
// Shared definitions for the floating-point exception status unit.
// Assumes single-precision style encodings, sized through module parameters.
package fpx_pkg;
    localparam int STAT_W    = 16;
    localparam int BIT_DZ    = 9;
    localparam int BIT_UNF   = 10;
    localparam int BIT_OVF   = 11;
    localparam int BIT_OPERR = 12;
    localparam int BIT_SNAN  = 13;
    localparam int BIT_NAN   = 14;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_ABS   = 2'd1,
        CLS_F2I   = 2'd2,
        CLS_RSVD  = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        OVR_NONE    = 2'd0,
        OVR_QNAN    = 2'd1,
        OVR_ALLONES = 2'd2,
        OVR_SAT     = 2'd3
    } ovr_kind_e;

    typedef struct packed {
        logic nan;
        logic snan;
        logic operr;
        logic ovf;
        logic unf;
    } fp_flags_t;
endpackage

// File: rtl/fpx_classify.sv
// Combinational outcome classifier: turns one operation's indications into
// the five floating-point flags and the kind of result override needed.
// Assumes a snan indication also counts as a NaN, and biased signed exponents.
module fpx_classify
    import fpx_pkg::*;
#(
    parameter int EXP_W = 8,
    localparam int XW   = EXP_W + 2
) (
    input  op_class_e             cls,
    input  logic                  a_nan,
    input  logic                  a_snan,
    input  logic                  b_nan,
    input  logic                  b_snan,
    input  logic                  a_inf,
    input  logic                  b_inf,
    input  logic                  invalid,
    input  logic                  mag_zero,
    input  logic signed [XW-1:0]  exp_unrnd,
    input  logic signed [XW-1:0]  exp_rnd,
    output fp_flags_t             flags,
    output ovr_kind_e             kind
);
    localparam int EXP_TOP = (1 << EXP_W) - 1;
    localparam logic signed [XW-1:0] EXP_TOP_S = XW'(EXP_TOP);

    logic any_snan, any_nan, any_inf, is_conv, is_abs, inv_hit, nan_out;
    logic unf_raw, ovf_raw;

    // Operand summaries shared by every class.
    always_comb begin
        any_snan = a_snan | b_snan;
        any_nan  = a_nan | b_nan | any_snan;
        any_inf  = a_inf | b_inf;
        is_conv  = (cls == CLS_F2I);
        is_abs   = (cls == CLS_ABS);
        inv_hit  = invalid & ~is_conv & ~is_abs;
        nan_out  = any_nan | inv_hit;
        unf_raw  = ~mag_zero & (exp_unrnd <= XW'(0));
        ovf_raw  = (exp_rnd >= EXP_TOP_S);
    end

    // Flag and override selection with NaN outcomes taking precedence.
    always_comb begin
        flags = '0;
        kind  = OVR_NONE;
        if (is_conv) begin
            flags.nan  = any_nan;
            flags.snan = any_snan;
            kind       = any_nan ? OVR_ALLONES : OVR_NONE;
        end else begin
            flags.snan  = any_snan;
            flags.operr = inv_hit;
            flags.nan   = nan_out;
            flags.unf   = ~nan_out & ~any_inf & unf_raw;
            flags.ovf   = ~nan_out & ~any_inf & ovf_raw;
            if (nan_out)        kind = OVR_QNAN;
            else if (flags.ovf) kind = OVR_SAT;
        end
    end
endmodule

// File: rtl/fpx_ovf_select.sv
// Override word generator: builds the replacement result for the kind chosen
// by the classifier, using rounding mode and sign for overflow.
// Assumes IEEE layout sign | exponent | mantissa.
module fpx_ovf_select
    import fpx_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int MANT_W = 23,
    localparam int W     = 1 + EXP_W + MANT_W
) (
    input  ovr_kind_e       kind,
    input  rmode_e          rmode,
    input  logic            sign,
    output logic [W-1:0]    word
);
    logic [W-1:0] w_inf, w_max, w_qnan;
    logic         pick_inf;

    // Fixed encodings for the candidate words.
    always_comb begin
        w_inf  = {sign, {EXP_W{1'b1}}, {MANT_W{1'b0}}};
        w_max  = {sign, {(EXP_W-1){1'b1}}, 1'b0, {MANT_W{1'b1}}};
        w_qnan = {1'b0, {EXP_W{1'b1}}, {MANT_W{1'b1}}};
    end

    // Rounding-direction decision: infinity or saturate to largest finite.
    always_comb begin
        unique case (rmode)
            RM_NEAR: pick_inf = 1'b1;
            RM_ZERO: pick_inf = 1'b0;
            RM_UP:   pick_inf = ~sign;
            RM_DOWN: pick_inf = sign;
            default: pick_inf = 1'b1;
        endcase
    end

    // Final word per override kind.
    always_comb begin
        unique case (kind)
            OVR_QNAN:    word = w_qnan;
            OVR_ALLONES: word = {W{1'b1}};
            OVR_SAT:     word = pick_inf ? w_inf : w_max;
            default:     word = '0;
        endcase
    end
endmodule

// File: rtl/fpx_flag_reg.sv
// Flag and override storage: floating-point operations overwrite the five
// flags, the divide-by-zero bit follows software writes and is cleared by
// floating-point operations; override outputs last one cycle.
// Assumes fp_op is already qualified by the strobe and the float tag.
module fpx_flag_reg
    import fpx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fp_op,
    input  logic        dz_wr_en,
    input  logic        dz_wr_val,
    input  fp_flags_t   new_flags,
    input  logic        new_ovr,
    input  logic [W-1:0] new_word,
    output fp_flags_t   flags_q,
    output logic        dz_q,
    output logic        ovr_q,
    output logic [W-1:0] word_q
);
    // Five floating-point flags: replaced by each floating-point operation.
    always_ff @(posedge clk) begin
        if (!rst_n)     flags_q <= '0;
        else if (fp_op) flags_q <= new_flags;
    end

    // Divide-by-zero: a software write wins over the clear by an operation.
    always_ff @(posedge clk) begin
        if (!rst_n)        dz_q <= 1'b0;
        else if (dz_wr_en) dz_q <= dz_wr_val;
        else if (fp_op)    dz_q <= 1'b0;
    end

    // Override outputs: valid only in the cycle after an overriding operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q  <= 1'b0;
            word_q <= '0;
        end else begin
            ovr_q  <= fp_op & new_ovr;
            word_q <= (fp_op & new_ovr) ? new_word : '0;
        end
    end

    a_r2_dz_cleared_by_op: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_op && !dz_wr_en) |=> !dz_q);
    a_r2_dz_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        dz_wr_en |=> (dz_q == $past(dz_wr_val)));
    a_r10_no_ovr_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_op |=> (!ovr_q && word_q == '0));
endmodule

// File: rtl/fpx_status_unit.sv
// Floating-point exception status unit (top). Registers the six status flags
// at their fixed positions and the result override for each operation.
// Assumes the datapath supplies rounded/unrounded exponents and operand kinds.
module fpx_status_unit
    import fpx_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int MANT_W = 23,
    localparam int XW    = EXP_W + 2,
    localparam int W     = 1 + EXP_W + MANT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic                 op_is_float,
    input  logic [1:0]           op_class,
    input  logic                 src_a_nan,
    input  logic                 src_a_snan,
    input  logic                 src_b_nan,
    input  logic                 src_b_snan,
    input  logic                 src_a_inf,
    input  logic                 src_b_inf,
    input  logic                 op_invalid,
    input  logic                 mag_zero,
    input  logic                 res_sign,
    input  logic [XW-1:0]        exp_unrnd,
    input  logic [XW-1:0]        exp_rnd,
    input  logic [1:0]           rnd_mode,
    input  logic                 dz_wr_en,
    input  logic                 dz_wr_val,
    output logic [STAT_W-1:0]    status,
    output logic                 res_ovr,
    output logic [W-1:0]         res_word
);
    fp_flags_t    cls_flags, flags_q;
    ovr_kind_e    kind;
    logic [W-1:0] sel_word;
    logic         fp_op, dz_q;

    // Qualified floating-point operation strobe.
    assign fp_op = op_valid & op_is_float;

    fpx_classify #(.EXP_W(EXP_W)) u_classify (
        .cls       (op_class_e'(op_class)),
        .a_nan     (src_a_nan),
        .a_snan    (src_a_snan),
        .b_nan     (src_b_nan),
        .b_snan    (src_b_snan),
        .a_inf     (src_a_inf),
        .b_inf     (src_b_inf),
        .invalid   (op_invalid),
        .mag_zero  (mag_zero),
        .exp_unrnd ($signed(exp_unrnd)),
        .exp_rnd   ($signed(exp_rnd)),
        .flags     (cls_flags),
        .kind      (kind)
    );

    fpx_ovf_select #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_select (
        .kind  (kind),
        .rmode (rmode_e'(rnd_mode)),
        .sign  (res_sign),
        .word  (sel_word)
    );

    fpx_flag_reg #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .fp_op     (fp_op),
        .dz_wr_en  (dz_wr_en),
        .dz_wr_val (dz_wr_val),
        .new_flags (cls_flags),
        .new_ovr   (kind != OVR_NONE),
        .new_word  (sel_word),
        .flags_q   (flags_q),
        .dz_q      (dz_q),
        .ovr_q     (res_ovr),
        .word_q    (res_word)
    );

    // Map stored flags onto their fixed status positions.
    always_comb begin
        status            = '0;
        status[BIT_DZ]    = dz_q;
        status[BIT_UNF]   = flags_q.unf;
        status[BIT_OVF]   = flags_q.ovf;
        status[BIT_OPERR] = flags_q.operr;
        status[BIT_SNAN]  = flags_q.snan;
        status[BIT_NAN]   = flags_q.nan;
    end

    a_r3_fixed_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_is_float && !dz_wr_en) |=> ($stable(status) && !res_ovr));
    a_r6_ovf_has_override: assert property (@(posedge clk) disable iff (!rst_n)
        fp_op |=> (!status[BIT_OVF] || res_ovr));
    a_r7_operr_implies_nan: assert property (@(posedge clk) disable iff (!rst_n)
        status[BIT_OPERR] |-> status[BIT_NAN]);
    a_r9_conv_no_range_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_op && op_class == 2'd2) |=>
            !(status[BIT_OVF] || status[BIT_UNF] || status[BIT_OPERR]));
    a_r11_nan_excludes_range: assert property (@(posedge clk) disable iff (!rst_n)
        status[BIT_NAN] |-> !(status[BIT_OVF] || status[BIT_UNF]));
endmodule

// File: tb/tb_fpx_status_unit.sv
module tb_fpx_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_is_float = 1'b0;
    logic [1:0]  op_class = 2'd0;
    logic        src_a_nan = 1'b0, src_a_snan = 1'b0, src_b_nan = 1'b0, src_b_snan = 1'b0;
    logic        src_a_inf = 1'b0, src_b_inf = 1'b0;
    logic        op_invalid = 1'b0, mag_zero = 1'b0, res_sign = 1'b0;
    logic [9:0]  exp_unrnd = '0, exp_rnd = '0;
    logic [1:0]  rnd_mode = 2'd0;
    logic        dz_wr_en = 1'b0, dz_wr_val = 1'b0;
    logic [15:0] status;
    logic        res_ovr;
    logic [31:0] res_word;

    int checks = 0;
    int fails  = 0;

    logic [15:0] q_stat[$];
    logic        q_ovr[$];
    logic [31:0] q_word[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    fpx_status_unit dut (.*);

    // Monitor: compares registered outputs just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (q_stat.size() != 0) begin
            logic [15:0] es;
            logic        eo;
            logic [31:0] ew;
            string       tg;
            es = q_stat.pop_front();
            eo = q_ovr.pop_front();
            ew = q_word.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if (status !== es || res_ovr !== eo || res_word !== ew) begin
                fails++;
                $display("FAIL %s actual status=%h ovr=%b word=%h expected status=%h ovr=%b word=%h",
                         tg, status, res_ovr, res_word, es, eo, ew);
            end
        end
    end

    // Driver: applies one operation for one cycle and queues its expected outcome.
    task automatic drive(input logic isf, input logic [1:0] cls, input logic [3:0] nans,
                         input logic [1:0] infs, input logic inv, input logic zero,
                         input logic sgn, input int ue, input int re, input logic [1:0] rm,
                         input logic dzw, input logic [15:0] es, input logic eo,
                         input logic [31:0] ew, input string tg);
        @(negedge clk);
        op_valid = 1'b1; op_is_float = isf; op_class = cls;
        {src_a_nan, src_a_snan, src_b_nan, src_b_snan} = nans;
        {src_a_inf, src_b_inf} = infs;
        op_invalid = inv; mag_zero = zero; res_sign = sgn;
        exp_unrnd = ue[9:0]; exp_rnd = re[9:0]; rnd_mode = rm;
        dz_wr_en = dzw; dz_wr_val = dzw;
        q_stat.push_back(es); q_ovr.push_back(eo); q_word.push_back(ew); q_tag.push_back(tg);
        @(negedge clk);
        op_valid = 1'b0; dz_wr_en = 1'b0; dz_wr_val = 1'b0;
    endtask

    task automatic dz_write(input logic v, input logic [15:0] es, input string tg);
        @(negedge clk);
        dz_wr_en = 1'b1; dz_wr_val = v;
        q_stat.push_back(es); q_ovr.push_back(1'b0); q_word.push_back(32'h0); q_tag.push_back(tg);
        @(negedge clk);
        dz_wr_en = 1'b0; dz_wr_val = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (status !== 16'h0 || res_ovr !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset actual status=%h ovr=%b expected status=0000 ovr=0", status, res_ovr);
        end
        // args: isf cls nans infs inv zero sgn ue re rm dzw | status ovr word
        dz_write(1'b1, 16'h0200, "R2 software sets dz");
        drive(1, 0, 4'b0, 2'b0, 0, 0, 0, 100, 100, 0, 0, 16'h0000, 0, 32'h0, "R2 float op clears dz");
        drive(1, 0, 4'b0, 2'b0, 0, 0, 0, 0, 1, 0, 0, 16'h0400, 0, 32'h0, "R4 unf before rounding");
        drive(1, 0, 4'b0, 2'b0, 0, 0, 0, -5, -5, 0, 0, 16'h0400, 0, 32'h0, "R4 negative exponent");
        drive(1, 0, 4'b0, 2'b0, 0, 1, 0, 0, 0, 0, 0, 16'h0000, 0, 32'h0, "R4 zero magnitude");
        drive(1, 0, 4'b0, 2'b0, 0, 0, 0, 254, 254, 0, 0, 16'h0000, 0, 32'h0, "R5 largest finite nearest");
        drive(1, 0, 4'b0, 2'b0, 0, 0, 0, 254, 254, 3, 0, 16'h0000, 0, 32'h0, "R5 largest finite down");
        drive(1, 0, 4'b0, 2'b0, 0, 0, 0, 254, 255, 0, 0, 16'h0800, 1, 32'h7F800000, "R6 nearest pos");
        drive(1, 0, 4'b0, 2'b0, 0, 0, 1, 254, 255, 0, 0, 16'h0800, 1, 32'hFF800000, "R6 nearest neg");
        drive(1, 0, 4'b0, 2'b0, 0, 0, 0, 254, 255, 1, 0, 16'h0800, 1, 32'h7F7FFFFF, "R6 zero pos");
        drive(1, 0, 4'b0, 2'b0, 0, 0, 1, 254, 255, 1, 0, 16'h0800, 1, 32'hFF7FFFFF, "R6 zero neg");
        drive(1, 0, 4'b0, 2'b0, 0, 0, 0, 254, 255, 2, 0, 16'h0800, 1, 32'h7F800000, "R6 up pos");
        drive(1, 0, 4'b0, 2'b0, 0, 0, 1, 254, 255, 2, 0, 16'h0800, 1, 32'hFF7FFFFF, "R6 up neg");
        drive(1, 0, 4'b0, 2'b0, 0, 0, 0, 254, 255, 3, 0, 16'h0800, 1, 32'h7F7FFFFF, "R6 down pos");
        drive(1, 0, 4'b0, 2'b0, 0, 0, 1, 254, 255, 3, 0, 16'h0800, 1, 32'hFF800000, "R6 down neg");
        drive(1, 0, 4'b0, 2'b0, 0, 0, 0, 255, 256, 0, 0, 16'h0800, 1, 32'h7F800000, "R5 carry past top");
        drive(0, 0, 4'b0, 2'b0, 1, 0, 0, 0, 0, 0, 0, 16'h0800, 0, 32'h0, "R3 fixed op keeps flags");
        dz_write(1'b1, 16'h0A00, "R2 write keeps others");
        drive(0, 0, 4'b1111, 2'b0, 0, 0, 0, 300, 300, 0, 0, 16'h0A00, 0, 32'h0, "R3 fixed keeps dz");
        drive(1, 0, 4'b0, 2'b0, 1, 0, 0, 100, 100, 0, 0, 16'h5000, 1, 32'h7FFFFFFF, "R7 invalid");
        drive(1, 0, 4'b0011, 2'b0, 0, 0, 0, 100, 100, 0, 0, 16'h6000, 1, 32'h7FFFFFFF, "R8 snan arith");
        drive(1, 0, 4'b1000, 2'b0, 0, 0, 0, 100, 100, 0, 0, 16'h4000, 1, 32'h7FFFFFFF, "R8 qnan arith");
        drive(1, 1, 4'b1100, 2'b0, 0, 0, 0, 100, 100, 0, 0, 16'h6000, 1, 32'h7FFFFFFF, "R8 snan abs");
        drive(1, 2, 4'b1000, 2'b0, 0, 0, 0, 100, 100, 0, 0, 16'h4000, 1, 32'hFFFFFFFF, "R9 conv qnan");
        drive(1, 2, 4'b1100, 2'b0, 0, 0, 0, 300, 300, 0, 0, 16'h6000, 1, 32'hFFFFFFFF, "R9 conv snan");
        drive(1, 2, 4'b0, 2'b0, 1, 0, 0, 300, 300, 0, 0, 16'h0000, 0, 32'h0, "R9 conv no range flags");
        drive(1, 0, 4'b0, 2'b10, 0, 0, 0, 255, 255, 0, 0, 16'h0000, 0, 32'h0, "R5 inf operand no ovf");
        drive(1, 0, 4'b1000, 2'b0, 0, 0, 0, 0, 300, 0, 0, 16'h4000, 1, 32'h7FFFFFFF, "R11 nan over range");
        drive(1, 0, 4'b0, 2'b0, 0, 0, 0, 100, 100, 0, 1, 16'h0200, 0, 32'h0, "R2 write beats clear R10 overwrite");
        dz_write(1'b0, 16'h0000, "R2 software clears dz");
        @(negedge clk);
        q_stat.push_back(16'h0); q_ovr.push_back(1'b0); q_word.push_back(32'h0);
        q_tag.push_back("R10 idle no override R1 layout");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule